// File: doc/BRIEF.md
# Mode-Switched Multiplexed I/O Port Bank

This block is a small bank of CPU-visible port registers whose pins change their job with the chip's operating mode. In the two local modes (bootstrap and single-chip) it gives the CPU four ports: two output-only bytes, one bidirectional byte with its own direction register, and a further byte whose pins each follow a direction bit. In the two bus modes (test and expanded) the same pins carry the external bus. The two output bytes carry the high and low halves of the address. The bidirectional byte becomes the data bus, turned around by the bus read/write signal. The top pin of the fourth port becomes an active-low program chip select that is always driven.

The mode is taken from `mode_sel` while `rst` is high and is then held until the next reset. A two-state machine records the choice: `ST_LOCAL` (ports under CPU control) and `ST_BUS` (ports lent to the external bus). While `rst` is high, `mode_sel` 00 or 01 takes the next state to `ST_LOCAL` and 10 or 11 takes it to `ST_BUS`. With `rst` low the state holds, so there is no other transition. In `ST_BUS` the data registers of the three bus-owned ports drop out of the register map.

Top module: `mux_port_bank`

## Requirements
- R1: A direction bit of 1 enables the pin's output driver and 0 leaves the pin an input. Both direction registers (offset 0x03 for port G and 0x07 for port C) clear to 0 on reset.
- R2: The register offsets on `reg_addr` are 0x02 port G data, 0x03 port G direction, 0x04 port B data, 0x05 port F data, 0x06 port C data and 0x07 port C direction. Any other offset reads 0, and a write to it changes nothing.
- R3: In the local modes, ports B and F drive their data registers with every output enable set to 1, and both registers reset to 0.
- R4: In the bus modes, `pb_out` equals `ext_addr[15:8]` and `pf_out` equals `ext_addr[7:0]`, with all their output enables at 1.
- R5: In the local modes, `pc_oe` follows the port C direction register and is therefore 0 after reset. `pc_out` drives the port C data latch.
- R6: In the bus modes, `pc_out` equals `ext_wdata`. All of `pc_oe` is 1 when `ext_rnw` is 0 and 0 when `ext_rnw` is 1, and `ext_rdata` equals `pc_in`. In the local modes `ext_rdata` is 0.
- R7: In the bus modes, `pg_oe[7]` is 1 and `pg_out[7]` is the program chip select, while the port G direction register still reads back the value it holds (0 after reset).
- R8: A read of port G or port C data returns `pg_in`/`pc_in` for bits whose direction bit is 0 and the data latch for bits whose direction bit is 1. Reads of ports B and F return their latches.
- R9: In the bus modes, writes to offsets 0x04, 0x05 and 0x06 are ignored and reads from them return 0.
- R10: The `mode_sel` encoding is 00 bootstrap, 01 single-chip, 10 test and 11 expanded. It is sampled on each clock edge while `rst` is 1 and has no effect while `rst` is 0.
- R11: The chip select `pg_out[7]` is 0 exactly when `PROG_BASE <= ext_addr <= PROG_LAST` (defaults 0x8000 and 0xFFFF) and 1 otherwise.
- R12: Reset is synchronous and active high, and it clears every data and direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; mode is sampled while high |
| mode_sel | input | 2 | Operating mode: 00 bootstrap, 01 single-chip, 10 test, 11 expanded |
| reg_wr | input | 1 | CPU register write strobe |
| reg_addr | input | 3 | CPU register offset |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data (combinational) |
| ext_addr | input | 16 | External bus address |
| ext_rnw | input | 1 | External bus direction, 1 = read |
| ext_wdata | input | 8 | External bus write data |
| ext_rdata | output | 8 | External bus read data taken from the port C pins |
| pb_out | output | 8 | Port B pin output value |
| pb_oe | output | 8 | Port B output enables |
| pf_out | output | 8 | Port F pin output value |
| pf_oe | output | 8 | Port F output enables |
| pc_in | input | 8 | Port C pin input levels |
| pc_out | output | 8 | Port C pin output value |
| pc_oe | output | 8 | Port C output enables |
| pg_in | input | 8 | Port G pin input levels |
| pg_out | output | 8 | Port G pin output value (bit 7 is the chip select in bus modes) |
| pg_oe | output | 8 | Port G output enables |

## Verification
The hardest situation to reach is evidence that the mode does not move once reset is released, together with evidence that a write to a hidden register leaves no trace. The only way into another mode is a fresh reset, and that reset also clears the registers a stray write might have reached. The bench therefore applies several resets, each with a different `mode_sel`. Within a bus-mode session it toggles `mode_sel` and writes the hidden offsets, then observes at the pins and on the register read port that the address still comes out and that the reads still return 0.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [1:0] {
        MD_BOOT     = 2'b00,
        MD_SINGLE   = 2'b01,
        MD_TEST     = 2'b10,
        MD_EXPANDED = 2'b11
    } op_mode_t;

    typedef enum logic [0:0] {
        ST_LOCAL = 1'b0,
        ST_BUS   = 1'b1
    } port_state_t;

    localparam logic [REG_ADDR_W-1:0] OFF_GDAT = 3'd2;
    localparam logic [REG_ADDR_W-1:0] OFF_GDIR = 3'd3;
    localparam logic [REG_ADDR_W-1:0] OFF_BDAT = 3'd4;
    localparam logic [REG_ADDR_W-1:0] OFF_FDAT = 3'd5;
    localparam logic [REG_ADDR_W-1:0] OFF_CDAT = 3'd6;
    localparam logic [REG_ADDR_W-1:0] OFF_CDIR = 3'd7;

endpackage

// File: rtl/mpb_mode_fsm.sv
module mpb_mode_fsm
    import mpb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    output logic       bus_mode
);

    port_state_t state_q;
    port_state_t state_d;
    op_mode_t    mode_in;

    assign mode_in = op_mode_t'(mode_sel);

    // next state: the mode is only looked at while reset is held
    always_comb begin
        state_d = state_q;
        if (rst) begin
            unique case (mode_in)
                MD_BOOT,
                MD_SINGLE:   state_d = ST_LOCAL;
                MD_TEST,
                MD_EXPANDED: state_d = ST_BUS;
                default:     state_d = ST_LOCAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_LOCAL: bus_mode = 1'b0;
            ST_BUS:   bus_mode = 1'b1;
            default:  bus_mode = 1'b0;
        endcase
    end

endmodule

// File: rtl/mpb_regfile.sv
module mpb_regfile
    import mpb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_mode,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [PORT_W-1:0]     reg_wdata,
    input  logic [PORT_W-1:0]     pc_in,
    input  logic [PORT_W-1:0]     pg_in,
    output logic [PORT_W-1:0]     reg_rdata,
    output logic [PORT_W-1:0]     pb_q,
    output logic [PORT_W-1:0]     pf_q,
    output logic [PORT_W-1:0]     pc_q,
    output logic [PORT_W-1:0]     ddrc_q,
    output logic [PORT_W-1:0]     pg_q,
    output logic [PORT_W-1:0]     ddrg_q
);

    logic local_ok;
    logic [PORT_W-1:0] pg_view;
    logic [PORT_W-1:0] pc_view;

    assign local_ok = ~bus_mode;

    // register writes; bus-owned data registers are out of the map in bus modes
    always_ff @(posedge clk) begin
        if (rst) begin
            pb_q   <= '0;
            pf_q   <= '0;
            pc_q   <= '0;
            ddrc_q <= '0;
            pg_q   <= '0;
            ddrg_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFF_GDAT: pg_q   <= reg_wdata;
                OFF_GDIR: ddrg_q <= reg_wdata;
                OFF_BDAT: if (local_ok) pb_q <= reg_wdata;
                OFF_FDAT: if (local_ok) pf_q <= reg_wdata;
                OFF_CDAT: if (local_ok) pc_q <= reg_wdata;
                OFF_CDIR: ddrc_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // per-bit read view: latch for outputs, pin level for inputs
    for (genvar b = 0; b < PORT_W; b++) begin : g_view
        assign pg_view[b] = ddrg_q[b] ? pg_q[b] : pg_in[b];
        assign pc_view[b] = ddrc_q[b] ? pc_q[b] : pc_in[b];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_GDAT: reg_rdata = pg_view;
            OFF_GDIR: reg_rdata = ddrg_q;
            OFF_BDAT: reg_rdata = local_ok ? pb_q : '0;
            OFF_FDAT: reg_rdata = local_ok ? pf_q : '0;
            OFF_CDAT: reg_rdata = local_ok ? pc_view : '0;
            OFF_CDIR: reg_rdata = ddrc_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mpb_csel.sv
module mpb_csel #(
    parameter int                 ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  PROG_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0]  PROG_LAST = 16'hFFFF
) (
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              cs_n
);

    logic above_base;
    logic below_last;

    assign above_base = (ext_addr >= PROG_BASE);
    assign below_last = (ext_addr <= PROG_LAST);
    assign cs_n       = ~(above_base & below_last);

endmodule

// File: rtl/mpb_pin_mux.sv
module mpb_pin_mux #(
    parameter int PORT_W = 8
) (
    input  logic                  bus_mode,
    input  logic [2*PORT_W-1:0]   ext_addr,
    input  logic                  ext_rnw,
    input  logic [PORT_W-1:0]     ext_wdata,
    output logic [PORT_W-1:0]     ext_rdata,
    input  logic                  cs_n,
    input  logic [PORT_W-1:0]     pb_q,
    input  logic [PORT_W-1:0]     pf_q,
    input  logic [PORT_W-1:0]     pc_q,
    input  logic [PORT_W-1:0]     ddrc_q,
    input  logic [PORT_W-1:0]     pg_q,
    input  logic [PORT_W-1:0]     ddrg_q,
    input  logic [PORT_W-1:0]     pc_in,
    output logic [PORT_W-1:0]     pb_out,
    output logic [PORT_W-1:0]     pb_oe,
    output logic [PORT_W-1:0]     pf_out,
    output logic [PORT_W-1:0]     pf_oe,
    output logic [PORT_W-1:0]     pc_out,
    output logic [PORT_W-1:0]     pc_oe,
    output logic [PORT_W-1:0]     pg_out,
    output logic [PORT_W-1:0]     pg_oe
);

    localparam int TOP = PORT_W - 1;

    always_comb begin
        pb_oe = '1;
        pf_oe = '1;
        if (bus_mode) begin
            pb_out    = ext_addr[2*PORT_W-1:PORT_W];
            pf_out    = ext_addr[PORT_W-1:0];
            pc_out    = ext_wdata;
            pc_oe     = {PORT_W{~ext_rnw}};
            ext_rdata = pc_in;
        end else begin
            pb_out    = pb_q;
            pf_out    = pf_q;
            pc_out    = pc_q;
            pc_oe     = ddrc_q;
            ext_rdata = '0;
        end
    end

    always_comb begin
        pg_out = pg_q;
        pg_oe  = ddrg_q;
        if (bus_mode) begin
            pg_out[TOP] = cs_n;
            pg_oe[TOP]  = 1'b1;
        end
    end

endmodule

// File: rtl/mux_port_bank.sv
module mux_port_bank
    import mpb_pkg::*;
#(
    parameter int                  PORT_W    = 8,
    parameter logic [2*PORT_W-1:0] PROG_BASE = 16'h8000,
    parameter logic [2*PORT_W-1:0] PROG_LAST = 16'hFFFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            mode_sel,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [PORT_W-1:0]     reg_wdata,
    output logic [PORT_W-1:0]     reg_rdata,
    input  logic [2*PORT_W-1:0]   ext_addr,
    input  logic                  ext_rnw,
    input  logic [PORT_W-1:0]     ext_wdata,
    output logic [PORT_W-1:0]     ext_rdata,
    output logic [PORT_W-1:0]     pb_out,
    output logic [PORT_W-1:0]     pb_oe,
    output logic [PORT_W-1:0]     pf_out,
    output logic [PORT_W-1:0]     pf_oe,
    input  logic [PORT_W-1:0]     pc_in,
    output logic [PORT_W-1:0]     pc_out,
    output logic [PORT_W-1:0]     pc_oe,
    input  logic [PORT_W-1:0]     pg_in,
    output logic [PORT_W-1:0]     pg_out,
    output logic [PORT_W-1:0]     pg_oe
);

    localparam int EXT_AW = 2 * PORT_W;

    logic              bus_mode;
    logic              cs_n;
    logic [PORT_W-1:0] pb_q, pf_q, pc_q, ddrc_q, pg_q, ddrg_q;

    mpb_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .bus_mode (bus_mode)
    );

    mpb_regfile #(.PORT_W(PORT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_mode  (bus_mode),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pc_in     (pc_in),
        .pg_in     (pg_in),
        .reg_rdata (reg_rdata),
        .pb_q      (pb_q),
        .pf_q      (pf_q),
        .pc_q      (pc_q),
        .ddrc_q    (ddrc_q),
        .pg_q      (pg_q),
        .ddrg_q    (ddrg_q)
    );

    mpb_csel #(
        .ADDR_W    (EXT_AW),
        .PROG_BASE (PROG_BASE),
        .PROG_LAST (PROG_LAST)
    ) u_csel (
        .ext_addr (ext_addr),
        .cs_n     (cs_n)
    );

    mpb_pin_mux #(.PORT_W(PORT_W)) u_mux (
        .bus_mode  (bus_mode),
        .ext_addr  (ext_addr),
        .ext_rnw   (ext_rnw),
        .ext_wdata (ext_wdata),
        .ext_rdata (ext_rdata),
        .cs_n      (cs_n),
        .pb_q      (pb_q),
        .pf_q      (pf_q),
        .pc_q      (pc_q),
        .ddrc_q    (ddrc_q),
        .pg_q      (pg_q),
        .ddrg_q    (ddrg_q),
        .pc_in     (pc_in),
        .pb_out    (pb_out),
        .pb_oe     (pb_oe),
        .pf_out    (pf_out),
        .pf_oe     (pf_oe),
        .pc_out    (pc_out),
        .pc_oe     (pc_oe),
        .pg_out    (pg_out),
        .pg_oe     (pg_oe)
    );

endmodule

// File: rtl/mpb_checks.sv
module mpb_checks
    import mpb_pkg::*;
#(
    parameter int                  PORT_W    = 8,
    parameter logic [2*PORT_W-1:0] PROG_BASE = 16'h8000,
    parameter logic [2*PORT_W-1:0] PROG_LAST = 16'hFFFF
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_mode,
    input logic                  reg_wr,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [PORT_W-1:0]     reg_wdata,
    input logic [PORT_W-1:0]     reg_rdata,
    input logic [2*PORT_W-1:0]   ext_addr,
    input logic                  ext_rnw,
    input logic [PORT_W-1:0]     pb_out,
    input logic [PORT_W-1:0]     pb_oe,
    input logic [PORT_W-1:0]     pf_out,
    input logic [PORT_W-1:0]     pc_oe,
    input logic [PORT_W-1:0]     pg_out,
    input logic [PORT_W-1:0]     pg_oe
);

    logic in_window;
    logic hidden_off;

    assign in_window  = (ext_addr >= PROG_BASE) && (ext_addr <= PROG_LAST);
    assign hidden_off = (reg_addr == OFF_BDAT) || (reg_addr == OFF_FDAT) ||
                        (reg_addr == OFF_CDAT);

    assert_addr_drive_R4: assert property (@(posedge clk) disable iff (rst)
        bus_mode |-> (pb_out == ext_addr[2*PORT_W-1:PORT_W]) &&
                     (pf_out == ext_addr[PORT_W-1:0]) && (&pb_oe));

    assert_data_turn_R6: assert property (@(posedge clk) disable iff (rst)
        bus_mode |-> (pc_oe == {PORT_W{~ext_rnw}}));

    assert_cs_forced_R7: assert property (@(posedge clk) disable iff (rst)
        bus_mode |-> pg_oe[PORT_W-1]);

    assert_cs_window_R11: assert property (@(posedge clk) disable iff (rst)
        bus_mode |-> (pg_out[PORT_W-1] == !in_window));

    assert_hidden_read_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_mode && hidden_off) |-> (reg_rdata == '0));

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(bus_mode));

    assert_dir_enable_R1: assert property (@(posedge clk) disable iff (rst)
        (!bus_mode && !$past(rst) && $past(reg_wr) && ($past(reg_addr) == OFF_CDIR))
        |-> (pc_oe == $past(reg_wdata)));

endmodule

bind mux_port_bank mpb_checks #(
    .PORT_W    (PORT_W),
    .PROG_BASE (PROG_BASE),
    .PROG_LAST (PROG_LAST)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_mode  (bus_mode),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ext_addr  (ext_addr),
    .ext_rnw   (ext_rnw),
    .pb_out    (pb_out),
    .pb_oe     (pb_oe),
    .pf_out    (pf_out),
    .pc_oe     (pc_oe),
    .pg_out    (pg_out),
    .pg_oe     (pg_oe)
);

// File: tb/mux_port_bank_tb_top.sv
`timescale 1ns/1ps
module mux_port_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_sel;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [15:0] ext_addr;
    logic        ext_rnw;
    logic [7:0]  ext_wdata;
    logic [7:0]  ext_rdata;
    logic [7:0]  pb_out, pb_oe, pf_out, pf_oe;
    logic [7:0]  pc_in, pc_out, pc_oe;
    logic [7:0]  pg_in, pg_out, pg_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mux_port_bank dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_addr(ext_addr), .ext_rnw(ext_rnw), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .pb_out(pb_out), .pb_oe(pb_oe), .pf_out(pf_out), .pf_oe(pf_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .pg_in(pg_in), .pg_out(pg_out), .pg_oe(pg_oe)
    );

    // {wr, offset, wdata, pin level, expected read}
    localparam int NVEC = 14;
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 3'd3, 8'h00, 8'h00, 8'h00},
        {1'b1, 3'd4, 8'hA5, 8'h00, 8'h00},
        {1'b0, 3'd4, 8'h00, 8'h00, 8'hA5},
        {1'b1, 3'd5, 8'h3C, 8'h00, 8'h00},
        {1'b0, 3'd5, 8'h00, 8'h00, 8'h3C},
        {1'b1, 3'd7, 8'hF0, 8'h00, 8'h00},
        {1'b1, 3'd6, 8'h5A, 8'h00, 8'h00},
        {1'b0, 3'd6, 8'h00, 8'h0F, 8'h5F},
        {1'b1, 3'd3, 8'h81, 8'h00, 8'h00},
        {1'b1, 3'd2, 8'hC3, 8'h00, 8'h00},
        {1'b0, 3'd2, 8'h00, 8'h3C, 8'hBD},
        {1'b0, 3'd7, 8'h00, 8'h00, 8'hF0},
        {1'b1, 3'd1, 8'hFF, 8'h00, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; mode_sel = m; reg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic reg_read(input logic [2:0] a, input logic [7:0] pins, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; pc_in = pins; pg_in = pins;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        rst = 1'b1; mode_sel = 2'b01; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        ext_addr = '0; ext_rnw = 1'b1; ext_wdata = '0; pc_in = '0; pg_in = '0;

        // single-chip mode: reset state
        do_reset(2'b01);
        check("R12 R3 pb_out reset", {8'h0, pb_out}, 16'h0000);
        check("R3 pb/pf oe", {pb_oe, pf_oe}, 16'hFFFF);
        check("R5 R1 pc_oe reset", {8'h0, pc_oe}, 16'h0000);
        check("R1 pg_oe reset", {8'h0, pg_oe}, 16'h0000);

        // table walk: R2 offsets, R8 read merging
        for (int i = 0; i < NVEC; i++) begin
            logic [27:0] v;
            v = VEC[i];
            if (v[27]) reg_write(v[26:24], v[23:16]);
            else begin
                reg_read(v[26:24], v[15:8], rd);
                check($sformatf("R2 R8 vector %0d", i), {8'h0, rd}, {8'h0, v[7:0]});
            end
        end

        check("R3 pb/pf drive latches", {pb_out, pf_out}, 16'hA53C);
        check("R5 pc pins", {pc_out, pc_oe}, 16'h5AF0);
        check("R1 pg_oe follows dir", {8'h0, pg_oe}, 16'h0081);
        check("R6 ext_rdata local", {8'h0, ext_rdata}, 16'h0000);

        // expanded mode
        ext_addr = 16'h1234; ext_rnw = 1'b0; ext_wdata = 8'h96; pc_in = 8'h69;
        do_reset(2'b11);
        check("R4 address out", {pb_out, pf_out}, 16'h1234);
        check("R4 address oe", {pb_oe, pf_oe}, 16'hFFFF);
        check("R6 data write drive", {pc_out, pc_oe}, 16'h96FF);
        @(negedge clk); ext_rnw = 1'b1; #1;
        check("R6 data read", {ext_rdata, pc_oe}, 16'h6900);
        check("R7 cs forced out", {7'h0, pg_oe[7], 8'h0}, 16'h0100);
        reg_read(3'd3, 8'h00, rd);
        check("R7 dir reads 0", {8'h0, rd}, 16'h0000);
        check("R11 below window", {15'h0, pg_out[7]}, 16'h0001);
        @(negedge clk); ext_addr = 16'h8000; #1;
        check("R11 window base", {15'h0, pg_out[7]}, 16'h0000);
        @(negedge clk); ext_addr = 16'hFFFF; #1;
        check("R11 window top", {15'h0, pg_out[7]}, 16'h0000);
        @(negedge clk); ext_addr = 16'h7FFF; #1;
        check("R11 just below", {15'h0, pg_out[7]}, 16'h0001);

        // hidden registers in bus mode
        reg_write(3'd4, 8'h55);
        reg_write(3'd6, 8'h77);
        reg_read(3'd4, 8'hFF, rd);
        check("R9 hidden B read", {8'h0, rd}, 16'h0000);
        reg_read(3'd6, 8'hFF, rd);
        check("R9 hidden C read", {8'h0, rd}, 16'h0000);
        check("R9 B pins keep address", {8'h0, pb_out}, 16'h007F);

        // mode pin changes without reset are ignored
        @(negedge clk); mode_sel = 2'b00;
        @(negedge clk); @(negedge clk); #1;
        check("R10 mode held", {8'h0, pb_out}, 16'h007F);

        // bootstrap mode
        do_reset(2'b00);
        check("R10 boot local", {pb_out, pf_out}, 16'h0000);
        reg_write(3'd5, 8'h42);
        check("R3 boot F write", {8'h0, pf_out}, 16'h0042);

        // test mode
        ext_addr = 16'hABCD;
        do_reset(2'b10);
        check("R10 test bus", {pb_out, pf_out}, 16'hABCD);

        finish_run();
    end

endmodule